// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This controller sits between a clocked host and an external asynchronous static RAM of 65,536 one-bit words. The RAM has its own data-in and data-out pins, an active-low chip select and an active-low write strobe. The host offers one request at a time with a valid/ready handshake. Each request carries a 16-bit address, a write flag and a write bit. A read returns one bit together with a single-cycle valid pulse.

The analogue timing limits of the RAM are turned into whole clock cycles by three parameters. `READ_WAIT` is the number of cycles the chip stays selected before data-out is sampled. `WR_PULSE` is the length of the write-strobe low pulse. `RECOVER` is the number of deselected cycles that separate one access from the next. Each write frames its strobe with one setup cycle before the strobe falls and one hold cycle after it rises. This keeps the address and write bit stable on both sides of the strobe. Whenever no access is running, the chip is deselected, so the RAM rests in its low-power state between requests.

Top module: `sram_async_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `mem_ce_n` and `mem_we_n` are 1, `rsp_valid` is 0 and `req_ready` is 1.
- R2: `req_ready` is 1 only while the controller is idle. A request is taken at the rising edge where `req_valid` and `req_ready` are both 1, and `req_ready` is 0 in the following cycle. A `req_valid` that is high while `req_ready` is 0 has no effect on the pins or on the response.
- R3: A write (`req_wr`=1) drives, in order: 1 cycle with `mem_ce_n`=0 and `mem_we_n`=1, then `WR_PULSE` cycles with both at 0, then 1 cycle with `mem_ce_n`=0 and `mem_we_n`=1.
- R4: While `mem_ce_n` is 0, `mem_addr` equals the accepted address and does not change. During a write, `mem_din` also equals the accepted write bit and does not change.
- R5: `mem_we_n` is 0 only in cycles where `mem_ce_n` is 0.
- R6: A read (`req_wr`=0) holds `mem_ce_n`=0 and `mem_we_n`=1 for `READ_WAIT` cycles. `mem_dout` is sampled at the clock edge that ends the last of those cycles.
- R7: After every access, `mem_ce_n` is 1 for `RECOVER` cycles with `req_ready`=0. The controller then becomes idle again.
- R8: `rsp_valid` is a one-cycle pulse. It is raised only in the first recovery cycle of a read and never after a write.
- R9: Whenever `req_ready` is 1, `mem_ce_n` and `mem_we_n` are both 1.
- R10: `rsp_rdata` returns the bit most recently written to the same address, including the lowest and highest addresses and overwritten locations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_addr | input | 16 | Word address of the request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 1 | Bit to store on a write |
| rsp_valid | output | 1 | One-cycle pulse marking read data |
| rsp_rdata | output | 1 | Bit returned by a read |
| mem_addr | output | 16 | RAM address pins |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_din | output | 1 | RAM data-in pin |
| mem_dout | input | 1 | RAM data-out pin |

## Verification
The bound assertions check, on every cycle, the pin rules that need no memory contents. These are: the strobe only inside a select, stable address and write bit throughout a select, the exact strobe length, the select length before the response, the single-cycle response, recovery before ready, and the deselected idle state. Other points can only be shown by the bench scenarios against its behavioural RAM model. That model returns wrong data until the select has lasted `READ_WAIT` cycles, so it exposes sampling one cycle too early, data actually written to the RAM and read back, and host requests that are ignored while busy.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    localparam int unsigned ADDR_W = 16;

    // Phases of one access
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_WSETUP = 3'd1,
        PH_WPULSE = 3'd2,
        PH_WHOLD  = 3'd3,
        PH_RWAIT  = 3'd4,
        PH_RECOV  = 3'd5
    } phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic              wdata;
    } host_req_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              ce_n;
        logic              we_n;
        logic              din;
    } pin_bus_t;

    // Zero-length phases are not allowed; clamp to one cycle
    function automatic int unsigned at_least_one(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Chip selected in this phase
    function automatic logic phase_selects(input phase_e p);
        return (p == PH_WSETUP) || (p == PH_WPULSE) ||
               (p == PH_WHOLD)  || (p == PH_RWAIT);
    endfunction

    // Write strobe asserted in this phase
    function automatic logic phase_strobes(input phase_e p);
        return (p == PH_WPULSE);
    endfunction

endpackage

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned READ_WAIT = 3,
    parameter int unsigned WR_PULSE  = 3,
    parameter int unsigned RECOVER   = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   accept,
    input  logic   acc_wr,
    output phase_e phase_q,
    output phase_e phase_d,
    output logic   phase_last
);

    localparam int unsigned RW    = at_least_one(READ_WAIT);
    localparam int unsigned PW    = at_least_one(WR_PULSE);
    localparam int unsigned RC    = at_least_one(RECOVER);
    localparam int unsigned LMAX  = max3(RW, PW, RC);
    localparam int unsigned CNT_W = (LMAX < 2) ? 1 : $clog2(LMAX);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len_m1;

    // Final count value of the current phase
    always_comb begin
        case (phase_q)
            PH_WPULSE: len_m1 = CNT_W'(PW - 1);
            PH_RWAIT:  len_m1 = CNT_W'(RW - 1);
            PH_RECOV:  len_m1 = CNT_W'(RC - 1);
            default:   len_m1 = '0;
        endcase
    end

    assign phase_last = (cnt_q == len_m1);

    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE: begin
                if (accept) phase_d = acc_wr ? PH_WSETUP : PH_RWAIT;
            end
            PH_WSETUP: phase_d = PH_WPULSE;
            PH_WPULSE: if (phase_last) phase_d = PH_WHOLD;
            PH_WHOLD:  phase_d = PH_RECOV;
            PH_RWAIT:  if (phase_last) phase_d = PH_RECOV;
            PH_RECOV:  if (phase_last) phase_d = PH_IDLE;
            default:   phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            if ((phase_d != phase_q) || (phase_q == PH_IDLE)) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
    import sram_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_wdata,
    input  phase_e            phase_d,
    output pin_bus_t          pins
);

    // Pins come straight from flops, decoded from the next phase,
    // so they change once per edge and never glitch
    always_ff @(posedge clk) begin
        if (rst) begin
            pins.addr <= '0;
            pins.din  <= 1'b0;
            pins.ce_n <= 1'b1;
            pins.we_n <= 1'b1;
        end else begin
            if (accept) begin
                pins.addr <= acc_addr;
                pins.din  <= acc_wdata;
            end
            pins.ce_n <= !phase_selects(phase_d);
            pins.we_n <= !phase_strobes(phase_d);
        end
    end

endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture
    import sram_ctrl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_e phase_q,
    input  logic   phase_last,
    input  logic   mem_dout,
    output logic   rsp_valid,
    output logic   rsp_rdata
);

    logic take;

    assign take = (phase_q == PH_RWAIT) && phase_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= 1'b0;
        end else begin
            rsp_valid <= take;
            if (take) rsp_rdata <= mem_dout;
        end
    end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned READ_WAIT = 3,
    parameter int unsigned WR_PULSE  = 3,
    parameter int unsigned RECOVER   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wr,
    input  logic              req_wdata,
    output logic              rsp_valid,
    output logic              rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_din,
    input  logic              mem_dout
);

    host_req_t req;
    phase_e    phase_q;
    phase_e    phase_d;
    logic      phase_last;
    logic      accept;
    pin_bus_t  pins;

    assign req       = '{addr: req_addr, wr: req_wr, wdata: req_wdata};
    assign req_ready = (phase_q == PH_IDLE);
    assign accept    = req_valid && req_ready;

    sram_phase_seq #(
        .READ_WAIT (READ_WAIT),
        .WR_PULSE  (WR_PULSE),
        .RECOVER   (RECOVER)
    ) seq_i (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .acc_wr     (req.wr),
        .phase_q    (phase_q),
        .phase_d    (phase_d),
        .phase_last (phase_last)
    );

    sram_pin_drive pins_i (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .acc_addr  (req.addr),
        .acc_wdata (req.wdata),
        .phase_d   (phase_d),
        .pins      (pins)
    );

    sram_read_capture cap_i (
        .clk        (clk),
        .rst        (rst),
        .phase_q    (phase_q),
        .phase_last (phase_last),
        .mem_dout   (mem_dout),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata)
    );

    assign mem_addr = pins.addr;
    assign mem_ce_n = pins.ce_n;
    assign mem_we_n = pins.we_n;
    assign mem_din  = pins.din;

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned READ_WAIT = 3,
    parameter int unsigned WR_PULSE  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_din
);

    localparam int unsigned RW = at_least_one(READ_WAIT);
    localparam int unsigned PW = at_least_one(WR_PULSE);

    logic [31:0] strobe_run;
    logic [31:0] sense_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_run <= '0;
            sense_run  <= '0;
        end else begin
            strobe_run <= !mem_we_n ? strobe_run + 1 : '0;
            sense_run  <= (!mem_ce_n && mem_we_n) ? sense_run + 1 : '0;
        end
    end

    // R5
    we_inside_ce_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> !mem_ce_n);

    // R4
    pins_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_din)));

    // R3
    strobe_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (strobe_run == PW));

    // R6
    sense_len_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ((sense_run == RW) && mem_ce_n));

    // R8
    rsp_single_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R9
    idle_deselect_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_ce_n && mem_we_n));

    // R2
    busy_after_take_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R7
    recover_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_ce_n) |-> !req_ready);

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
    .READ_WAIT (READ_WAIT),
    .WR_PULSE  (WR_PULSE)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_din   (mem_din)
);

// File: tb/sram_async_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb_top;

    localparam int unsigned READ_WAIT = 3;
    localparam int unsigned WR_PULSE  = 3;
    localparam int unsigned RECOVER   = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic        req_wr = 1'b0;
    logic        req_wdata = 1'b0;
    logic        rsp_valid;
    logic        rsp_rdata;
    logic [15:0] mem_addr;
    logic        mem_ce_n;
    logic        mem_we_n;
    logic        mem_din;
    logic        mem_dout = 1'b0;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sram_async_ctrl #(
        .READ_WAIT (READ_WAIT),
        .WR_PULSE  (WR_PULSE),
        .RECOVER   (RECOVER)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_wr    (req_wr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .mem_addr  (mem_addr),
        .mem_ce_n  (mem_ce_n),
        .mem_we_n  (mem_we_n),
        .mem_din   (mem_din),
        .mem_dout  (mem_dout)
    );

    // Expected pin/handshake state for one cycle
    typedef struct {
        bit    ce_n;
        bit    we_n;
        bit    rdy;
        bit    rv;
        bit    rd;
        bit    chk_din;
        string tag;
    } exp_t;

    exp_t        expq[$];
    bit          ref_mem[int];
    bit          ram_mem[int];
    logic [15:0] exp_addr = '0;
    bit          exp_din = 0;
    bit          prev_we_n = 1;
    int          sense_cnt = 0;
    logic [15:0] prev_addr = '0;

    task automatic chk(input logic [15:0] act, input logic [15:0] exp,
                       input string req, input string what);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit ram_rd(input logic [15:0] a);
        return ram_mem.exists(int'(a)) ? ram_mem[int'(a)] : 1'b0;
    endfunction

    // Behavioural RAM: commits on strobe rise, returns valid data only
    // after READ_WAIT selected cycles on a stable address
    task automatic ram_model();
        if (!prev_we_n && mem_we_n && !mem_ce_n)
            ram_mem[int'(mem_addr)] = mem_din;
        if (!mem_ce_n && mem_we_n)
            sense_cnt = (sense_cnt > 0 && mem_addr == prev_addr) ? sense_cnt + 1 : 1;
        else
            sense_cnt = 0;
        prev_we_n = mem_we_n;
        prev_addr = mem_addr;
        mem_dout  = (sense_cnt >= READ_WAIT) ? ram_rd(mem_addr) : ~ram_rd(mem_addr);
    endtask

    task automatic step();
        exp_t e;
        @(negedge clk);
        if (expq.size() > 0) e = expq.pop_front();
        else e = '{ce_n: 1, we_n: 1, rdy: 1, rv: 0, rd: 0, chk_din: 0, tag: "R9"};
        chk(16'(mem_ce_n), 16'(e.ce_n), e.tag, "mem_ce_n");
        chk(16'(mem_we_n), 16'(e.we_n), e.tag, "mem_we_n");
        chk(16'(req_ready), 16'(e.rdy), "R2", "req_ready");
        chk(16'(rsp_valid), 16'(e.rv), "R8", "rsp_valid");
        if (e.rv) chk(16'(rsp_rdata), 16'(e.rd), "R10", "rsp_rdata");
        if (!e.ce_n) begin
            chk(mem_addr, exp_addr, "R4", "mem_addr");
            if (e.chk_din) chk(16'(mem_din), 16'(exp_din), "R4", "mem_din");
        end
        ram_model();
    endtask

    task automatic do_req(input bit wr, input logic [15:0] a, input bit d, input bit poke);
        bit rb;
        step();  // an idle cycle: request is offered here
        req_valid = 1'b1;
        req_wr    = wr;
        req_addr  = a;
        req_wdata = d;
        exp_addr  = a;
        exp_din   = d;
        if (wr) begin
            ref_mem[int'(a)] = d;
            expq.push_back('{ce_n: 0, we_n: 1, rdy: 0, rv: 0, rd: 0, chk_din: 1, tag: "R3"});
            for (int i = 0; i < WR_PULSE; i++)
                expq.push_back('{ce_n: 0, we_n: 0, rdy: 0, rv: 0, rd: 0, chk_din: 1, tag: "R3"});
            expq.push_back('{ce_n: 0, we_n: 1, rdy: 0, rv: 0, rd: 0, chk_din: 1, tag: "R3"});
            for (int i = 0; i < RECOVER; i++)
                expq.push_back('{ce_n: 1, we_n: 1, rdy: 0, rv: 0, rd: 0, chk_din: 0, tag: "R7"});
        end else begin
            rb = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 1'b0;
            for (int i = 0; i < READ_WAIT; i++)
                expq.push_back('{ce_n: 0, we_n: 1, rdy: 0, rv: 0, rd: 0, chk_din: 0, tag: "R6"});
            for (int i = 0; i < RECOVER; i++)
                expq.push_back('{ce_n: 1, we_n: 1, rdy: 0, rv: (i == 0), rd: rb, chk_din: 0, tag: "R7"});
        end
        do begin
            step();
            // R2: requests offered while busy must be ignored
            req_valid = poke;
            req_wr    = ~wr;
            req_addr  = ~a;
            req_wdata = ~d;
        end while (expq.size() > 0);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(16'(mem_ce_n), 16'h1, "R1", "mem_ce_n in reset");
        chk(16'(mem_we_n), 16'h1, "R1", "mem_we_n in reset");
        chk(16'(rsp_valid), 16'h0, "R1", "rsp_valid in reset");
        rst = 1'b0;
        @(negedge clk);
        chk(16'(req_ready), 16'h1, "R1", "req_ready after reset");
        chk(16'(mem_ce_n), 16'h1, "R1", "mem_ce_n after reset");
        ram_model();

        // R3 R10: writes at both address extremes, then read back
        do_req(1, 16'hFFFF, 1, 0);
        do_req(1, 16'h0000, 0, 0);
        do_req(0, 16'hFFFF, 0, 0);
        do_req(0, 16'h0000, 0, 0);
        // R6: read of a never-written cell
        do_req(0, 16'h5A5A, 0, 0);
        // R2: busy-time requests with poke
        do_req(1, 16'h1234, 1, 1);
        do_req(0, 16'h1234, 0, 1);
        do_req(0, 16'hEDCB, 0, 1);
        // R10: overwrite then read
        do_req(1, 16'hFFFF, 0, 0);
        do_req(0, 16'hFFFF, 0, 0);
        // Spread pattern, writes then reads back
        for (int i = 0; i < 24; i++)
            do_req(1, 16'(i * 4099 + 7), bit'((i ^ (i >> 2)) & 1), bit'(i % 3 == 0));
        for (int i = 0; i < 24; i++)
            do_req(0, 16'(i * 4099 + 7), 0, bit'(i % 4 == 1));
        // R9: a few idle cycles at the end
        repeat (6) step();

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL R2 watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule